// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers a set of interrupt request lines and turns them into one interrupt request and a vector number for a processor. Every source has its own programmable priority level, an enable bit and a request bit that software can set. A source takes part in arbitration only when it is requesting, is enabled and has a nonzero level. It can win only if its level is strictly above the level of the routine now running.

The running level is held in a current-priority register. When the processor acknowledges, the block does three things in one clock cycle. It latches the winning source index into a read-only vector register. It saves the running level on a last-in-first-out stack. It raises the running level to the winner's level. An end-of-interrupt write takes the saved level back off the stack, so nested routines unwind in order. Requests that are below the running level wait, and they win later once the level has fallen beneath them.

All configuration goes through one write port: a strobe, an address and a data word. The top two address bits select a register space and the low bits select a source.

Top module: `prio_intc`

## Requirements
- R1: After reset, `irq_o` is 0, `cur_pri_o` is 0, `vec_o` is 0 and `err_o` is 0. All sources start disabled, with level 0 and the software request bit cleared.
- R2: A source whose level is 0 never causes `irq_o` and is never selected on acknowledge, even when it is enabled and requesting.
- R3: A source whose enable bit is 0 is ignored by arbitration, whatever its level and request.
- R4: A live source can be taken only if its level is strictly greater than `cur_pri_o`. A lower request stays pending, with `irq_o` low, until `cur_pri_o` drops below its level.
- R5: When several live sources share the highest eligible level, the one with the lowest index wins, independent of the order in which they were asserted.
- R6: When `ack_i` is high and a winner exists, in that same cycle `vec_o` takes the winner's index, `cur_pri_o` takes the winner's level and the old level is pushed on the stack. `vec_o` changes at no other time.
- R7: An end-of-interrupt write restores `cur_pri_o` to the level saved by the most recent unreturned acknowledge (last in, first out).
- R8: An end-of-interrupt write while the stack is empty sets `cur_pri_o` to 0 and sets `err_o`. `err_o` stays set until reset.
- R9: An acknowledge while the stack is full is still taken, but the push is dropped and `err_o` is set.
- R10: Each source has a software request bit that is OR-ed with its hardware line. Writing space 1 at that source index with data bit 0 = 1 sets the bit, and with data bit 0 = 0 clears it.
- R11: `irq_o` is registered. In each cycle it is computed from the live sources and the current priority that will hold after the clock edge. It therefore drops one cycle after the winning source negates, and it does not stay high after an acknowledge that leaves nothing above the new level.
- R12: Address map: `wr_addr_i[5:4]` selects the space and `wr_addr_i[3:0]` selects the source. Space 0 writes the level from `wr_data_i`. Space 1 writes the software request bit. Space 2 is end-of-interrupt, and its index is ignored. Space 3 writes the enable bit from `wr_data_i[0]`.
- R13: An acknowledge with no eligible source changes nothing. An acknowledge in the same cycle as an end-of-interrupt write is ignored, and only the end-of-interrupt takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | N_SRC | Hardware request line of each source |
| ack_i | input | 1 | Processor acknowledge strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | clog2(N_SRC)+2 | Register space (top two bits) and source index |
| wr_data_i | input | PRI_W | Write data (a level, or a bit in bit 0) |
| irq_o | output | 1 | Registered interrupt request to the processor |
| vec_o | output | clog2(N_SRC) | Index captured at the last taken acknowledge |
| cur_pri_o | output | PRI_W | Current running priority level |
| err_o | output | 1 | Sticky error for stack underflow or overflow |

## Verification
Arbitration is tried with one request at a time, with staggered requests at the same level, and with requests that arrive below the running level while a higher routine runs. The first pattern shows that eligibility is a strict comparison. The second separates lowest-index selection from arrival order. The third separates holding a request pending from taking it wrongly. Sources are also driven with a zero level, with enable cleared and through the software bit alone, which tells the three gating paths apart. Nesting deeper than a reduced stack, unwinding past the bottom, and an acknowledge that collides with end-of-interrupt check the error flag and the restore order against a queue model that is compared on every clock.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    // Register space selected by the two top address bits
    typedef enum logic [1:0] {
        SPACE_LEVEL = 2'b00,
        SPACE_SWREQ = 2'b01,
        SPACE_EOI   = 2'b10,
        SPACE_EN    = 2'b11
    } reg_space_e;

endpackage

// File: rtl/prio_intc_srcgate.sv
// Per-source qualification: requesting (hardware or software), enabled, nonzero level
module prio_intc_srcgate #(
    parameter int N_SRC = 16,
    parameter int PRI_W = 4
) (
    input  logic [N_SRC-1:0]             hw_i,
    input  logic [N_SRC-1:0]             sw_i,
    input  logic [N_SRC-1:0]             en_i,
    input  logic [N_SRC-1:0][PRI_W-1:0]  pri_i,
    output logic [N_SRC-1:0]             live_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign live_o[g] = (hw_i[g] | sw_i[g]) & en_i[g] & (|pri_i[g]);
    end

endmodule

// File: rtl/prio_intc_arbiter.sv
// Picks the highest level strictly above the threshold; ties go to the lowest index
module prio_intc_arbiter #(
    parameter int N_SRC = 16,
    parameter int PRI_W = 4,
    parameter int IDX_W = 4
) (
    input  logic [N_SRC-1:0]             live_i,
    input  logic [N_SRC-1:0][PRI_W-1:0]  pri_i,
    input  logic [PRI_W-1:0]             thr_i,
    output logic                         valid_o,
    output logic [IDX_W-1:0]             idx_o,
    output logic [PRI_W-1:0]             pri_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        pri_o   = thr_i;
        // ascending scan with strict compare keeps the first (lowest) index on a tie
        for (int i = 0; i < N_SRC; i++) begin
            if (live_i[i] && (pri_i[i] > pri_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                pri_o   = pri_i[i];
            end
        end
    end

endmodule

// File: rtl/prio_intc_above.sv
// Flags whether any live source sits strictly above a given level
module prio_intc_above #(
    parameter int N_SRC = 16,
    parameter int PRI_W = 4
) (
    input  logic [N_SRC-1:0]             live_i,
    input  logic [N_SRC-1:0][PRI_W-1:0]  pri_i,
    input  logic [PRI_W-1:0]             thr_i,
    output logic                         hit_o
);

    logic [N_SRC-1:0] over;

    for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
        assign over[g] = live_i[g] && (pri_i[g] > thr_i);
    end

    assign hit_o = |over;

endmodule

// File: rtl/prio_intc_stack.sv
// LIFO of saved priority levels; push on full and pop on empty are dropped
module prio_intc_stack #(
    parameter int DEPTH = 15,
    parameter int PRI_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [PRI_W-1:0] din_i,
    output logic [PRI_W-1:0] top_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][PRI_W-1:0] mem;
        logic [CNT_W-1:0]            cnt;
    } stk_t;

    stk_t s_d, s_q;

    logic [CNT_W-1:0] cnt_dec;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign cnt_dec = s_q.cnt - CNT_W'(1);
    assign wr_ptr  = s_q.cnt[PTR_W-1:0];
    assign rd_ptr  = cnt_dec[PTR_W-1:0];
    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == CNT_W'(DEPTH));
    assign top_o   = empty_o ? '0 : s_q.mem[rd_ptr];

    always_comb begin
        s_d = s_q;
        if (pop_i) begin
            if (!empty_o) begin
                s_d.cnt = cnt_dec;
            end
        end else if (push_i && !full_o) begin
            s_d.mem[wr_ptr] = din_i;
            s_d.cnt         = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N_SRC       = 16,
    parameter int PRI_W       = 4,
    parameter int STACK_DEPTH = (1 << PRI_W) - 1,
    localparam int IDX_W      = $clog2(N_SRC),
    localparam int ADDR_W     = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req_i,
    input  logic              ack_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [PRI_W-1:0]  wr_data_i,
    output logic              irq_o,
    output logic [IDX_W-1:0]  vec_o,
    output logic [PRI_W-1:0]  cur_pri_o,
    output logic              err_o
);

    typedef struct packed {
        logic [N_SRC-1:0][PRI_W-1:0] pri;
        logic [N_SRC-1:0]            en;
        logic [N_SRC-1:0]            sw;
        logic [PRI_W-1:0]            cur;
        logic [IDX_W-1:0]            vec;
        logic                        irq;
        logic                        err;
    } state_t;

    state_t st_d, st_q;

    // write-port decode
    reg_space_e       space;
    logic [IDX_W-1:0] sel;
    logic             eoi;
    logic             take;

    assign space = reg_space_e'(wr_addr_i[ADDR_W-1 -: 2]);
    assign sel   = wr_addr_i[IDX_W-1:0];
    assign eoi   = wr_en_i && (space == SPACE_EOI);

    // source qualification
    logic [N_SRC-1:0] live;

    prio_intc_srcgate #(.N_SRC(N_SRC), .PRI_W(PRI_W)) u_gate (
        .hw_i   (src_req_i),
        .sw_i   (st_q.sw),
        .en_i   (st_q.en),
        .pri_i  (st_q.pri),
        .live_o (live)
    );

    // winner against the running level
    logic             take_valid;
    logic [IDX_W-1:0] take_idx;
    logic [PRI_W-1:0] take_pri;

    prio_intc_arbiter #(.N_SRC(N_SRC), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_arb (
        .live_i  (live),
        .pri_i   (st_q.pri),
        .thr_i   (st_q.cur),
        .valid_o (take_valid),
        .idx_o   (take_idx),
        .pri_o   (take_pri)
    );

    assign take = ack_i && !eoi && take_valid;

    // saved-level stack
    logic [PRI_W-1:0] stk_top;
    logic             stk_empty;
    logic             stk_full;

    prio_intc_stack #(.DEPTH(STACK_DEPTH), .PRI_W(PRI_W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (take),
        .pop_i   (eoi),
        .din_i   (st_q.cur),
        .top_o   (stk_top),
        .empty_o (stk_empty),
        .full_o  (stk_full)
    );

    // next running level, vector and error
    logic [PRI_W-1:0] cur_d;
    logic [IDX_W-1:0] vec_d;
    logic             err_d;

    always_comb begin
        cur_d = st_q.cur;
        vec_d = st_q.vec;
        err_d = st_q.err;
        if (eoi) begin
            cur_d = stk_top;
            err_d = st_q.err | stk_empty;
        end else if (take) begin
            vec_d = take_idx;
            cur_d = take_pri;
            err_d = st_q.err | stk_full;
        end
    end

    // request line looks ahead to the level that holds after this edge
    logic irq_hit;

    prio_intc_above #(.N_SRC(N_SRC), .PRI_W(PRI_W)) u_above (
        .live_i (live),
        .pri_i  (st_q.pri),
        .thr_i  (cur_d),
        .hit_o  (irq_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cur = cur_d;
        st_d.vec = vec_d;
        st_d.err = err_d;
        st_d.irq = irq_hit;
        if (wr_en_i) begin
            unique case (space)
                SPACE_LEVEL: st_d.pri[sel] = wr_data_i;
                SPACE_SWREQ: st_d.sw[sel]  = wr_data_i[0];
                SPACE_EN:    st_d.en[sel]  = wr_data_i[0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o     = st_q.irq;
    assign vec_o     = st_q.vec;
    assign cur_pri_o = st_q.cur;
    assign err_o     = st_q.err;

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int PRI_W = 4,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take,
    input logic             eoi,
    input logic [PRI_W-1:0] take_pri,
    input logic             stk_empty,
    input logic             stk_full,
    input logic [PRI_W-1:0] cur,
    input logic [IDX_W-1:0] vec,
    input logic             irq,
    input logic             err
);

    p_nonzero_winner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (take_pri != '0));

    p_take_strictly_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (take_pri > cur));

    p_ack_loads_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cur == $past(take_pri)));

    p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(vec));

    p_eoi_lowers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !stk_empty) |=> (cur < $past(cur)));

    p_eoi_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && stk_empty) |=> ((cur == '0) && err));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_push_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && stk_full) |=> err);

    p_no_irq_at_ceiling_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cur != '1));

endmodule

bind prio_intc prio_intc_chk #(.PRI_W(PRI_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .eoi       (eoi),
    .take_pri  (take_pri),
    .stk_empty (stk_empty),
    .stk_full  (stk_full),
    .cur       (cur_pri_o),
    .vec       (vec_o),
    .irq       (irq_o),
    .err       (err_o)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;

    localparam int N     = 16;
    localparam int PW    = 4;
    localparam int DEPTH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_req = '0;
    logic          ack = 1'b0;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_addr = '0;
    logic [PW-1:0] wr_data = '0;
    logic          irq_o;
    logic [3:0]    vec_o;
    logic [PW-1:0] cur_pri_o;
    logic          err_o;

    prio_intc #(.N_SRC(N), .PRI_W(PW), .STACK_DEPTH(DEPTH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req_i (src_req),
        .ack_i     (ack),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .irq_o     (irq_o),
        .vec_o     (vec_o),
        .cur_pri_o (cur_pri_o),
        .err_o     (err_o)
    );

    always #5 clk = ~clk;

    // behavioural reference state
    int m_pri[N];
    int m_en[N];
    int m_sw[N];
    int m_cur, m_vec, m_irq, m_err;
    int m_stk[$];

    string tag = "R1";
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic chk(input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, name, act, exp);
        end
    endtask

    task automatic compare();
        chk("irq", int'(irq_o), m_irq);
        chk("vec", int'(vec_o), m_vec);
        chk("cur", int'(cur_pri_o), m_cur);
        chk("err", int'(err_o), m_err);
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_pri[i] = 0; m_en[i] = 0; m_sw[i] = 0;
        end
        m_cur = 0; m_vec = 0; m_irq = 0; m_err = 0;
        m_stk.delete();
    endtask

    function automatic bit is_live(input int i);
        return (src_req[i] || m_sw[i] != 0) && m_en[i] != 0;
    endfunction

    task automatic model_step();
        int  best = m_cur;
        int  bidx = 0;
        bit  found = 1'b0;
        int  sp = int'(wr_addr[5:4]);
        int  id = int'(wr_addr[3:0]);
        bit  is_eoi = wr_en && (sp == 2);
        int  ncur = m_cur;
        int  nvec = m_vec;
        int  nerr = m_err;
        int  nirq = 0;
        for (int i = 0; i < N; i++) begin
            if (is_live(i) && m_pri[i] > best) begin
                best = m_pri[i]; bidx = i; found = 1'b1;
            end
        end
        if (is_eoi) begin
            if (m_stk.size() == 0) begin
                ncur = 0; nerr = 1;
            end else begin
                ncur = m_stk.pop_back();
            end
        end else if (ack && found) begin
            nvec = bidx;
            ncur = best;
            if (m_stk.size() < DEPTH) m_stk.push_back(m_cur);
            else nerr = 1;
        end
        for (int i = 0; i < N; i++) begin
            if (is_live(i) && m_pri[i] > ncur) nirq = 1;
        end
        if (wr_en) begin
            if (sp == 0) m_pri[id] = int'(wr_data);
            if (sp == 1) m_sw[id]  = int'(wr_data[0]);
            if (sp == 3) m_en[id]  = int'(wr_data[0]);
        end
        m_cur = ncur; m_vec = nvec; m_err = nerr; m_irq = nirq;
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        ack   = 1'b0;
        wr_en = 1'b0;
        compare();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic wreg(input int sp, input int id, input int data);
        wr_en   = 1'b1;
        wr_addr = {2'(sp), 4'(id)};
        wr_data = PW'(data);
        cyc();
    endtask

    task automatic do_ack();
        ack = 1'b1;
        cyc();
    endtask

    task automatic do_eoi();
        wreg(2, 0, 0);
    endtask

    task automatic setup(input int id, input int lvl);
        wreg(0, id, lvl);
        wreg(3, id, 1);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        src_req = '0; ack = 1'b0; wr_en = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        idle(2);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        @(negedge clk);
        apply_reset();

        // R3: disabled source with a high level is ignored
        tag = "R3";
        wreg(0, 9, 7);
        src_req[9] = 1'b1;
        idle(3);
        do_ack();
        src_req[9] = 1'b0;

        // R2: enabled source at level 0 never requests
        tag = "R2";
        wreg(3, 10, 1);
        src_req[10] = 1'b1;
        idle(3);
        do_ack();
        src_req[10] = 1'b0;

        // R12: map levels and enables
        tag = "R12";
        setup(2, 1);
        setup(6, 4);
        setup(5, 3);
        setup(3, 3);

        // R4: single request, then preemption by a higher level
        tag = "R4";
        src_req[2] = 1'b1;
        idle(2);
        do_ack();
        src_req[2] = 1'b0;
        idle(1);
        src_req[6] = 1'b1;
        idle(2);
        do_ack();
        src_req[6] = 1'b0;

        // R4: lower requests arriving during level 4 stay pending
        src_req[5] = 1'b1;
        idle(1);
        src_req[3] = 1'b1;
        idle(2);
        do_ack();

        // R7: return to level 1 re-exposes the pending pair
        tag = "R7";
        do_eoi();
        idle(1);

        // R5: tie at level 3, lower index wins despite arriving later
        tag = "R5";
        do_ack();
        src_req[3] = 1'b0;
        do_eoi();
        do_ack();

        // R11: request drops one cycle after the winner negates
        tag = "R11";
        src_req[5] = 1'b0;
        idle(2);
        do_eoi();
        do_eoi();
        idle(1);

        // R10: software request bit set and cleared
        tag = "R10";
        setup(12, 6);
        wreg(1, 12, 1);
        idle(2);
        wreg(1, 12, 0);
        idle(2);

        // R13: acknowledge with nothing eligible
        tag = "R13";
        do_ack();
        idle(1);

        // R8: end-of-interrupt on an empty stack
        tag = "R8";
        do_eoi();
        idle(2);

        // R13: acknowledge colliding with end-of-interrupt
        tag = "R13";
        src_req[2] = 1'b1;
        idle(2);
        ack     = 1'b1;
        wr_en   = 1'b1;
        wr_addr = {2'd2, 4'd0};
        cyc();
        do_ack();
        src_req[2] = 1'b0;
        do_eoi();
        idle(1);

        // R9: nesting deeper than the stack
        apply_reset();
        tag = "R9";
        setup(1, 2);
        setup(4, 5);
        setup(7, 8);
        setup(8, 11);
        src_req[1] = 1'b1; idle(1); do_ack(); src_req[1] = 1'b0;
        src_req[4] = 1'b1; idle(1); do_ack(); src_req[4] = 1'b0;
        src_req[7] = 1'b1; idle(1); do_ack(); src_req[7] = 1'b0;
        src_req[8] = 1'b1; idle(1); do_ack(); src_req[8] = 1'b0;
        idle(1);
        tag = "R7";
        do_eoi();
        do_eoi();
        do_eoi();
        tag = "R8";
        do_eoi();
        idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog %s: got timeout expected completion", tag);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule